// File: doc/BRIEF.md
# ADC Digital Back-End Sequencer

This block sits behind the analog core of a pipelined 8-bit sampling converter. On every conversion clock it takes one raw offset-binary code and one raw over-range bit. Both travel down a fixed-length register pipeline. At the far end the code is turned into the coding selected by a strap and driven onto a parallel bus, together with an over-range flag and an output clock. A second strap can halve the input clock to make the conversion clock, so the board may supply a fast clock whose duty cycle is not 50%.

The block also sequences reset and calibration. A recalibration request is an active-low input that is only recognised when it is low at a conversion edge. Calibration begins when the request is released. A cycle counter stands in for the time the calibration takes. While the request is held low, the output clock stays low and the over-range flag is forced high. The flag stays high until calibration ends, and a one-clock done pulse marks that point. A data-valid output rises once the pipeline holds nothing but samples taken after calibration. At power-up the same calibration runs on its own, with the output clock held low for its whole length.

Top module: `adc_backend_seq`

## Requirements
- R1: The code on `raw_code` at a conversion edge n reaches `dout` after edge n+PIPE_LAT-1, so it passes through exactly PIPE_LAT conversion-clock registers. PIPE_LAT defaults to 28. The over-range bit travels with its code.
- R2: When `twos_n_strap` is 1, `dout` is offset binary, equal to the raw code. When it is 0, `dout` is two's complement, formed by inverting bit DATA_W-1 of the raw code. `ovr_out` is the same in both cases.
- R3: `rst_req_n` is recognised only when it is 0 at a conversion edge. A low pulse that starts and ends between two conversion edges changes no output.
- R4: After a conversion edge at which the request is recognised, and for as long as it stays recognised, the following hold: `clk_out` is 0, `ovr_out` is 1, `dvalid` is 0 and `dout` is 0.
- R5: Calibration begins at the first conversion edge that sees `rst_req_n` at 1 after a recognised request. It lasts CAL_CYC conversion clocks. At its last edge `cal_done` goes to 1 for exactly one conversion clock, and the forced 1 on `ovr_out` is released at that same edge.
- R6: `clk_out` starts toggling again right after the conversion edge that ends the hold, so it already runs while calibration is in progress.
- R7: After `arst_n` is released (two input-clock synchronizer stages), a power-up calibration of CAL_CYC conversion clocks runs by itself. During it `clk_out` stays 0 and `ovr_out` stays 1.
- R8: A request recognised during calibration aborts it. After the request is released, the full CAL_CYC count restarts.
- R9: When `div_n_strap` is 0, conversion edges fall on every second rising edge of `clk_in`, and a running `clk_out` is a 50% duty square wave at half the input rate. When it is 1, every rising edge is a conversion edge and a running `clk_out` follows `clk_in`.
- R10: `dvalid` rises PIPE_LAT conversion edges after the edge at which `cal_done` rises. Samples that are in the pipeline when a request is recognised are discarded, and `dout` reads 0 whenever `dvalid` is 0.
- R11: Once calibration is over, `ovr_out` is 1 exactly for the output samples whose raw over-range bit was 1. The output sample that follows an over-range sample reports normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock from the board |
| arst_n | input | 1 | Asynchronous active-low power-up reset |
| rst_req_n | input | 1 | Active-low recalibration request, sampled at conversion edges |
| div_n_strap | input | 1 | 0: conversion clock is clk_in / 2; 1: undivided |
| twos_n_strap | input | 1 | 0: two's complement output; 1: offset binary |
| raw_code | input | DATA_W | Raw offset-binary sample from the converter core |
| raw_ovr | input | 1 | Raw over-range bit for the same sample |
| clk_out | output | 1 | Gated output clock |
| dout | output | DATA_W | Formatted output code |
| ovr_out | output | 1 | Over-range flag, forced high during hold and calibration |
| dvalid | output | 1 | Pipeline holds only post-calibration samples |
| cal_done | output | 1 | One-conversion-clock pulse at the end of calibration |

## Verification
The main path is driven with random codes and sparse random over-range bits. These random runs show whether data emerges with the right latency and the right over-range bit attached. Four directed codes (00, 7F, 80, FF) are run under both straps to separate a correct MSB inversion from a wrong bit or a full negation. Request patterns are also checked: a sub-clock glitch, which must change nothing; a held request; a request that lands mid-calibration; and a two-cycle pulse in divide mode. Together these separate edge-sampled recognition from level sensitivity, distinguish a restarted count from a resumed one, and show that flushed samples never resurface.

// File: rtl/adc_be_pkg.sv
package adc_be_pkg;

  typedef enum logic [1:0] {
    ST_PWRCAL = 2'd0,
    ST_HOLD   = 2'd1,
    ST_CAL    = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_e;

endpackage

// File: rtl/adc_be_clkgen.sv
module adc_be_clkgen (
  input  logic clk_in,
  input  logic arst_n,
  input  logic div_n,
  input  logic run_en,
  output logic rst_n_int,
  output logic conv_en,
  output logic clk_out
);

  logic [1:0] sync_q;
  logic       phase_q;
  logic       phase_d;
  logic       div_sel;

  assign div_sel = ~div_n;

  // Reset asserts at once and is released after two clock edges.
  always_ff @(posedge clk_in or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_int = sync_q[1];

  // The phase bit toggles on rising edges only, so the halved clock has a 50% duty.
  always_comb begin
    phase_d = 1'b0;
    if (div_sel) phase_d = ~phase_q;
  end

  always_ff @(posedge clk_in or negedge rst_n_int) begin
    if (!rst_n_int) phase_q <= 1'b0;
    else            phase_q <= phase_d;
  end

  assign conv_en = div_sel ? ~phase_q : 1'b1;
  assign clk_out = run_en & (div_sel ? phase_q : clk_in);

endmodule

// File: rtl/adc_be_seq.sv
module adc_be_seq
  import adc_be_pkg::*;
#(
  parameter int CAL_CYC = 4096
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic conv_en,
  input  logic req_n,
  output logic cal_done,
  output logic run_en,
  output logic force_ovr,
  output logic flush,
  output logic fill_en
);

  localparam int CW = (CAL_CYC > 1) ? $clog2(CAL_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CAL_CYC - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (!req_n) begin
      state_d = ST_HOLD;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          state_d = ST_CAL;
          cnt_d   = '0;
        end
        ST_PWRCAL, ST_CAL: begin
          if (cnt_q == CNT_LAST) begin
            state_d = ST_RUN;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_PWRCAL;
      cnt_q    <= '0;
      cal_done <= 1'b0;
    end else if (conv_en) begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      cal_done <= done_d;
    end
  end

  assign run_en    = (state_q == ST_CAL) || (state_q == ST_RUN);
  assign force_ovr = (state_q != ST_RUN);
  assign fill_en   = (state_q == ST_RUN);
  assign flush     = ~req_n;

endmodule

// File: rtl/adc_be_pipe.sv
module adc_be_pipe #(
  parameter int W   = 8,
  parameter int LAT = 28
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic         conv_en,
  input  logic         flush,
  input  logic         fill_en,
  input  logic [W-1:0] code_in,
  input  logic         ovr_in,
  output logic [W-1:0] code_out,
  output logic         ovr_out,
  output logic         vld_out
);

  logic [LAT-1:0][W-1:0] code_q, code_d;
  logic [LAT-1:0]        ovr_q, ovr_d;
  logic [LAT-1:0]        vld_q, vld_d;

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign code_d[g] = code_in;
      assign ovr_d[g]  = ovr_in;
      assign vld_d[g]  = fill_en & ~flush;
    end else begin : g_body
      assign code_d[g] = code_q[g-1];
      assign ovr_d[g]  = ovr_q[g-1];
      assign vld_d[g]  = vld_q[g-1] & ~flush;
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ovr_q  <= '0;
      vld_q  <= '0;
    end else if (conv_en) begin
      code_q <= code_d;
      ovr_q  <= ovr_d;
      vld_q  <= vld_d;
    end
  end

  assign code_out = code_q[LAT-1];
  assign ovr_out  = ovr_q[LAT-1];
  assign vld_out  = vld_q[LAT-1];

endmodule

// File: rtl/adc_be_fmt.sv
module adc_be_fmt #(
  parameter int W = 8
) (
  input  logic         vld,
  input  logic [W-1:0] code,
  input  logic         ovr,
  input  logic         force_ovr,
  input  logic         twos_n,
  output logic [W-1:0] dout,
  output logic         ovr_out
);

  logic [W-1:0] coded;

  always_comb begin
    coded = code;
    if (!twos_n) coded[W-1] = ~code[W-1];
  end

  assign dout    = vld ? coded : '0;
  assign ovr_out = force_ovr | (vld & ovr);

endmodule

// File: rtl/adc_backend_seq.sv
module adc_backend_seq #(
  parameter int DATA_W   = 8,
  parameter int PIPE_LAT = 28,
  parameter int CAL_CYC  = 4096
) (
  input  logic              clk_in,
  input  logic              arst_n,
  input  logic              rst_req_n,
  input  logic              div_n_strap,
  input  logic              twos_n_strap,
  input  logic [DATA_W-1:0] raw_code,
  input  logic              raw_ovr,
  output logic              clk_out,
  output logic [DATA_W-1:0] dout,
  output logic              ovr_out,
  output logic              dvalid,
  output logic              cal_done
);

  logic              rst_n_int;
  logic              conv_en;
  logic              run_en;
  logic              force_ovr;
  logic              flush;
  logic              fill_en;
  logic [DATA_W-1:0] tail_code;
  logic              tail_ovr;

  adc_be_clkgen u_clk (
    .clk_in    (clk_in),
    .arst_n    (arst_n),
    .div_n     (div_n_strap),
    .run_en    (run_en),
    .rst_n_int (rst_n_int),
    .conv_en   (conv_en),
    .clk_out   (clk_out)
  );

  adc_be_seq #(.CAL_CYC(CAL_CYC)) u_seq (
    .clk_in    (clk_in),
    .rst_n     (rst_n_int),
    .conv_en   (conv_en),
    .req_n     (rst_req_n),
    .cal_done  (cal_done),
    .run_en    (run_en),
    .force_ovr (force_ovr),
    .flush     (flush),
    .fill_en   (fill_en)
  );

  adc_be_pipe #(.W(DATA_W), .LAT(PIPE_LAT)) u_pipe (
    .clk_in   (clk_in),
    .rst_n    (rst_n_int),
    .conv_en  (conv_en),
    .flush    (flush),
    .fill_en  (fill_en),
    .code_in  (raw_code),
    .ovr_in   (raw_ovr),
    .code_out (tail_code),
    .ovr_out  (tail_ovr),
    .vld_out  (dvalid)
  );

  adc_be_fmt #(.W(DATA_W)) u_fmt (
    .vld       (dvalid),
    .code      (tail_code),
    .ovr       (tail_ovr),
    .force_ovr (force_ovr),
    .twos_n    (twos_n_strap),
    .dout      (dout),
    .ovr_out   (ovr_out)
  );

endmodule

// File: rtl/adc_backend_seq_chk.sv
module adc_backend_seq_chk (
  input logic clk_in,
  input logic rst_n,
  input logic conv_en,
  input logic rst_req_n,
  input logic div_n_strap,
  input logic run_en,
  input logic ovr_out,
  input logic dvalid,
  input logic cal_done
);

  // R4: a recognised request forces the over-range flag on the next cycle
  p_hold_ovr_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
    (conv_en && !rst_req_n) |=> ovr_out);

  // R10: a recognised request empties the pipeline's valid marking
  p_flush_r10: assert property (@(posedge clk_in) disable iff (!rst_n)
    (conv_en && !rst_req_n) |=> !dvalid);

  // R10: the done pulse comes before any valid output
  p_done_first_r10: assert property (@(posedge clk_in) disable iff (!rst_n)
    cal_done |-> !dvalid);

  // R5: the forced flag is gone by the time done is shown
  p_done_ovr_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
    cal_done |-> !ovr_out);

  // R6: valid data only ever comes with a running output clock
  p_valid_clk_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
    dvalid |-> run_en);

  // R9: in divide mode two conversion edges are never adjacent
  p_half_rate_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!div_n_strap && conv_en) |=> (!conv_en || div_n_strap));

endmodule

bind adc_backend_seq adc_backend_seq_chk u_chk (
  .clk_in      (clk_in),
  .rst_n       (rst_n_int),
  .conv_en     (conv_en),
  .rst_req_n   (rst_req_n),
  .div_n_strap (div_n_strap),
  .run_en      (run_en),
  .ovr_out     (ovr_out),
  .dvalid      (dvalid),
  .cal_done    (cal_done)
);

// File: tb/adc_backend_seq_bench.sv
module adc_backend_seq_bench;

  localparam int CLK_T = 10;
  localparam int W     = 8;
  localparam int LAT   = 28;
  localparam int CAL   = 12;

  localparam int M_PWR  = 0;
  localparam int M_HOLD = 1;
  localparam int M_CAL  = 2;
  localparam int M_RUN  = 3;

  logic         clk_in;
  logic         arst_n;
  logic         rst_req_n;
  logic         div_n_strap;
  logic         twos_n_strap;
  logic [W-1:0] raw_code;
  logic         raw_ovr;
  logic         clk_out;
  logic [W-1:0] dout;
  logic         ovr_out;
  logic         dvalid;
  logic         cal_done;

  adc_backend_seq #(.DATA_W(W), .PIPE_LAT(LAT), .CAL_CYC(CAL)) u_adc_backend_seq (
    .clk_in       (clk_in),
    .arst_n       (arst_n),
    .rst_req_n    (rst_req_n),
    .div_n_strap  (div_n_strap),
    .twos_n_strap (twos_n_strap),
    .raw_code     (raw_code),
    .raw_ovr      (raw_ovr),
    .clk_out      (clk_out),
    .dout         (dout),
    .ovr_out      (ovr_out),
    .dvalid       (dvalid),
    .cal_done     (cal_done)
  );

  int n_chk;
  int n_fail;
  string cur_tag;
  string dtag;

  // Expected-value model built from the requirements.
  int           mstate;
  int           mcnt;
  int           msync;
  logic         mdone;
  logic         mph;
  logic         mv [LAT];
  logic         mo [LAT];
  logic [W-1:0] mc [LAT];

  initial begin
    clk_in = 1'b0;
    forever #(CLK_T/2) clk_in = ~clk_in;
  end

  function automatic logic [W-1:0] fmt_exp(input logic [W-1:0] c, input logic tn);
    return tn ? c : (c ^ (W'(1) << (W-1)));
  endfunction

  task automatic model_reset();
    mstate = M_PWR;
    mcnt   = 0;
    msync  = 0;
    mdone  = 1'b0;
    mph    = 1'b0;
    for (int i = 0; i < LAT; i++) begin
      mv[i] = 1'b0;
      mo[i] = 1'b0;
      mc[i] = '0;
    end
  endtask

  task automatic model_edge();
    logic conv;
    logic rec;
    if (!arst_n) begin
      model_reset();
      return;
    end
    if (msync < 2) begin
      msync++;
      return;
    end
    conv = div_n_strap ? 1'b1 : ~mph;
    mph  = div_n_strap ? 1'b0 : ~mph;
    if (!conv) return;
    rec = ~rst_req_n;
    for (int i = LAT-1; i > 0; i--) begin
      mv[i] = mv[i-1] & ~rec;
      mo[i] = mo[i-1];
      mc[i] = mc[i-1];
    end
    mv[0] = (mstate == M_RUN) & ~rec;
    mo[0] = raw_ovr;
    mc[0] = raw_code;
    mdone = 1'b0;
    if (rec) begin
      mstate = M_HOLD;
      mcnt   = 0;
    end else if (mstate == M_HOLD) begin
      mstate = M_CAL;
      mcnt   = 0;
    end else if (mstate == M_PWR || mstate == M_CAL) begin
      if (mcnt == CAL-1) begin
        mstate = M_RUN;
        mdone  = 1'b1;
      end else begin
        mcnt++;
      end
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic check_all();
    logic run;
    logic e_clk;
    logic e_ovr;
    logic [W-1:0] e_d;
    run   = (mstate == M_CAL) || (mstate == M_RUN);
    e_clk = run & (div_n_strap ? 1'b1 : mph);
    e_d   = mv[LAT-1] ? fmt_exp(mc[LAT-1], twos_n_strap) : '0;
    e_ovr = (mstate != M_RUN) | (mv[LAT-1] & mo[LAT-1]);
    chk(dtag,    "dout",     32'(dout),     32'(e_d));
    chk(cur_tag, "ovr_out",  32'(ovr_out),  32'(e_ovr));
    chk(cur_tag, "dvalid",   32'(dvalid),   32'(mv[LAT-1]));
    chk(cur_tag, "cal_done", 32'(cal_done), 32'(mdone));
    chk(cur_tag, "clk_out",  32'(clk_out),  32'(e_clk));
  endtask

  // One input clock: model the edge, check just after it while clk_in is
  // high, optionally glitch the request between edges, then drive inputs
  // at the falling edge.
  task automatic step(input bit glitch, input bit rnd);
    @(posedge clk_in);
    model_edge();
    #1;
    check_all();
    if (glitch) begin
      #1 rst_req_n = 1'b0;
      #2 rst_req_n = 1'b1;
    end
    @(negedge clk_in);
    if (rnd) begin
      raw_code = W'($urandom);
      raw_ovr  = ($urandom % 6) == 0;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_T * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] corner [4];
    n_chk  = 0;
    n_fail = 0;
    void'($urandom(32'd1234));
    corner[0] = 8'h00; corner[1] = 8'h7F; corner[2] = 8'h80; corner[3] = 8'hFF;
    model_reset();
    arst_n       = 1'b0;
    rst_req_n    = 1'b1;
    div_n_strap  = 1'b1;
    twos_n_strap = 1'b1;
    raw_code     = '0;
    raw_ovr      = 1'b0;
    dtag         = "R1";

    // R7: reset state and the power-up calibration
    cur_tag = "R7";
    repeat (3) step(0, 1);
    arst_n = 1'b1;
    repeat (CAL + 4) step(0, 1);

    // R10: pipeline refill after calibration, then steady random data
    cur_tag = "R10";
    repeat (LAT + 2) step(0, 1);
    cur_tag = "R11";
    repeat (40) step(0, 1);

    // R2: two's complement coding, with the corner codes
    twos_n_strap = 1'b0;
    dtag = "R2";
    for (int k = 0; k < 4; k++) begin
      raw_code = corner[k];
      step(0, 0);
    end
    repeat (LAT + 6) step(0, 1);
    twos_n_strap = 1'b1;
    for (int k = 0; k < 4; k++) begin
      raw_code = corner[k];
      step(0, 0);
    end
    repeat (LAT + 6) step(0, 1);
    dtag = "R1";

    // R3: glitches between edges must not be recognised
    cur_tag = "R3";
    repeat (6) step(1, 1);

    // R4: held request
    cur_tag = "R4";
    rst_req_n = 1'b0;
    repeat (3) step(0, 1);
    rst_req_n = 1'b1;
    // R6: output clock runs again during calibration
    cur_tag = "R6";
    repeat (5) step(0, 1);
    // R8: request during calibration restarts the count
    cur_tag = "R8";
    rst_req_n = 1'b0;
    step(0, 1);
    rst_req_n = 1'b1;
    repeat (CAL - 2) step(0, 1);
    cur_tag = "R5";
    repeat (6) step(0, 1);
    cur_tag = "R10";
    repeat (LAT + 4) step(0, 1);

    // R11: over-range burst and recovery
    cur_tag = "R11";
    raw_ovr = 1'b1;
    repeat (3) step(0, 0);
    raw_ovr = 1'b0;
    repeat (LAT + 5) step(0, 0);
    repeat (20) step(0, 1);

    // R9: divide-by-two conversion clock
    cur_tag = "R9";
    arst_n = 1'b0;
    div_n_strap = 1'b0;
    repeat (3) step(0, 1);
    arst_n = 1'b1;
    repeat (2 * (CAL + LAT) + 20) step(0, 1);
    // R3: a request held over exactly one conversion edge is recognised
    cur_tag = "R3";
    rst_req_n = 1'b0;
    repeat (2) step(0, 1);
    rst_req_n = 1'b1;
    cur_tag = "R9";
    repeat (2 * (CAL + LAT) + 10) step(0, 1);

    summary();
    $finish;
  end

endmodule